// File: doc/BRIEF.md
# Kogge-Stone Parallel Prefix Adder

This block adds two unsigned operands and a carry-in in a single combinational pass and returns the sum and a carry-out. It replaces the slow ripple chain with a prefix tree of minimum depth. At every level, the distance between the two groups that a cell merges doubles, and every bit position keeps a group signal of its own.

The work is split into three stages:
- **Pre-processing.** Each bit forms a generate term and a propagate term. The carry-in is folded into bit 0, so that bit's group already reaches below the least significant position.
- **Carry tree.** The tree has log2(WIDTH) levels: four for the default width of 16. Where a group already reaches down to the carry-in, a reduced cell computes the generate term only. Everywhere else a full cell computes both the group generate and the group propagate. The tree has WIDTH·log2(WIDTH) − WIDTH + 1 cells, which is 49 at the default width.
- **Post-processing.** Each sum bit is the operand XOR of that bit combined with the carry arriving from the position below it.

The block has no clock and no state. It is meant to sit inside a datapath stage. WIDTH must be a power of two.

Top module: `ks_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `cin_i`) modulo 2^WIDTH for every combination of operands and carry-in.
- R2: `cout_o` equals bit WIDTH of the full-width result `a_i` + `b_i` + `cin_i`.
- R3: When `a_i` is the bitwise complement of `b_i` (every bit propagates), `cout_o` equals `cin_i`. With `cin_i` = 1 this gives `sum_o` = 0. With `cin_i` = 0 this gives `sum_o` = all ones.
- R4: When both operands are zero, `cout_o` is 0 and `sum_o` equals `cin_i` in bit 0 and zero elsewhere.
- R5: When both operands are all ones, `cout_o` is 1 and `sum_o` is all ones in bits WIDTH−1 down to 1, with bit 0 equal to `cin_i`.
- R6: When `a_i[WIDTH-1]` equals `b_i[WIDTH-1]`, `cout_o` equals that bit value, whatever the lower bits and `cin_i` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| cin_i | input | 1 | Carry into the least significant bit |
| sum_o | output | WIDTH | Sum, modulo 2^WIDTH |
| cout_o | output | 1 | Carry out of the most significant bit |

## Verification
Whenever an input settles, the assertions compare the full result against a plain addition. They also check the special operand patterns of R3 to R5, and the generate/kill rule of R6 at every bit position of the tree. The assertions cannot show that the longest propagate path, the all-zero and all-ones corners, and a broad spread of random operands were actually reached. Only the bench's directed and random scenarios can demonstrate that, because they drive those patterns and compare each result with an independently computed sum.

// File: rtl/ks_adder_pkg.sv
package ks_adder_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Merge a higher group with the adjacent lower group into one group.
    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // Merge whose result reaches the carry-in: only the generate term matters.
    function automatic gp_t gp_merge_final(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/ks_gp_stage.sv
module ks_gp_stage
    import ks_adder_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output gp_t  [WIDTH-1:0] gp_o,
    output logic [WIDTH-1:0] half_o
);

    always_comb begin
        half_o = a_i ^ b_i;
        for (int i = 0; i < WIDTH; i++) begin
            gp_o[i].g = a_i[i] & b_i[i];
            gp_o[i].p = half_o[i];
        end
        // Bit 0 absorbs the carry-in: its group reaches position -1,
        // whose propagate is zero.
        gp_o[0].g = (a_i[0] & b_i[0]) | (half_o[0] & cin_i);
        gp_o[0].p = 1'b0;
    end

endmodule

// File: rtl/ks_prefix_tree.sv
module ks_prefix_tree
    import ks_adder_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  gp_t  [WIDTH-1:0] gp_i,
    output logic [WIDTH-1:0] carry_o
);

    localparam int LEVELS = $clog2(WIDTH);

    gp_t [WIDTH-1:0] lvl [LEVELS+1];

    assign lvl[0] = gp_i;

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int SPAN = 1 << l;
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            if (i < SPAN) begin : g_pass
                assign lvl[l+1][i] = lvl[l][i];
            end else if (i < 2 * SPAN) begin : g_gray
                assign lvl[l+1][i] = gp_merge_final(lvl[l][i], lvl[l][i-SPAN]);
            end else begin : g_black
                assign lvl[l+1][i] = gp_merge(lvl[l][i], lvl[l][i-SPAN]);
            end
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_out
        assign carry_o[i] = lvl[LEVELS][i].g;
    end

    // A bit with equal operand bits kills or generates regardless of lower bits.
    always_comb begin
        for (int i = 1; i < WIDTH; i++) begin
            if (!gp_i[i].p) begin
                AST_KILL_GEN: assert (carry_o[i] == gp_i[i].g); // R6
            end
        end
    end

endmodule

// File: rtl/ks_sum_stage.sv
module ks_sum_stage #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] half_i,
    input  logic [WIDTH-1:0] carry_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    assign sum_o  = half_i ^ {carry_i[WIDTH-2:0], cin_i};
    assign cout_o = carry_i[WIDTH-1];

endmodule

// File: rtl/ks_adder.sv
module ks_adder
    import ks_adder_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    gp_t  [WIDTH-1:0] gp;
    logic [WIDTH-1:0] half;
    logic [WIDTH-1:0] carry;

    ks_gp_stage #(.WIDTH(WIDTH)) u_pre (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .gp_o   (gp),
        .half_o (half)
    );

    ks_prefix_tree #(.WIDTH(WIDTH)) u_tree (
        .gp_i    (gp),
        .carry_o (carry)
    );

    ks_sum_stage #(.WIDTH(WIDTH)) u_post (
        .half_i  (half),
        .carry_i (carry),
        .cin_i   (cin_i),
        .sum_o   (sum_o),
        .cout_o  (cout_o)
    );

    logic [WIDTH:0] ref_total;
    assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    always_comb begin
        AST_SUM_MATCH: assert (sum_o == ref_total[WIDTH-1:0]); // R1
        AST_COUT_MATCH: assert (cout_o == ref_total[WIDTH]); // R2
        if (a_i == ~b_i) begin
            AST_ALL_PROP: assert (cout_o == cin_i && sum_o == {WIDTH{~cin_i}}); // R3
        end
        if (a_i == '0 && b_i == '0) begin
            AST_ZERO_OPS: assert (!cout_o && sum_o == {{(WIDTH-1){1'b0}}, cin_i}); // R4
        end
        if (&a_i && &b_i) begin
            AST_ONES_OPS: assert (cout_o && sum_o == {{(WIDTH-1){1'b1}}, cin_i}); // R5
        end
    end

endmodule

// File: tb/ks_adder_test.sv
`timescale 1ns/1ps
module ks_adder_test;

    localparam int WIDTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [WIDTH-1:0] a, b, sum;
    logic             cin, cout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ks_adder #(.WIDTH(WIDTH)) uut (
        .a_i    (a),
        .b_i    (b),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b (a=%h b=%h cin=%0b)",
                     req, act, exp, a, b, cin);
        end
    endtask

    task automatic check_vec(input string req, input logic [WIDTH-1:0] act,
                             input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h cin=%0b)",
                     req, act, exp, a, b, cin);
        end
    endtask

    // Drive after a rising edge, sample at the following falling edge.
    task automatic apply(input logic [WIDTH-1:0] av, input logic [WIDTH-1:0] bv,
                         input logic cv);
        longint unsigned total;
        @(posedge clk);
        #2;
        a = av; b = bv; cin = cv;
        @(negedge clk);
        total = longint'(av) + longint'(bv) + longint'(cv);
        check_vec("R1 sum", sum, total[WIDTH-1:0]);
        check_bit("R2 cout", cout, total[WIDTH]);
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: zero operands give zero result (R4)
        check_vec("R4 reset sum", sum, '0);
        check_bit("R4 reset cout", cout, 1'b0);
        rst = 1'b0;

        // R4 zero operands with carry-in
        apply('0, '0, 1'b1);
        check_vec("R4 sum", sum, 16'h0001);
        check_bit("R4 cout", cout, 1'b0);

        // R5 all ones
        apply('1, '1, 1'b0);
        check_vec("R5 sum", sum, 16'hFFFE);
        check_bit("R5 cout", cout, 1'b1);
        apply('1, '1, 1'b1);
        check_vec("R5 sum", sum, 16'hFFFF);
        check_bit("R5 cout", cout, 1'b1);

        // R3 all-propagate: longest carry path
        apply(16'hA5C3, 16'h5A3C, 1'b1);
        check_vec("R3 sum", sum, 16'h0000);
        check_bit("R3 cout", cout, 1'b1);
        apply(16'h0000, 16'hFFFF, 1'b1);
        check_vec("R3 sum", sum, 16'h0000);
        check_bit("R3 cout", cout, 1'b1);
        apply(16'h1234, 16'hEDCB, 1'b0);
        check_vec("R3 sum", sum, 16'hFFFF);
        check_bit("R3 cout", cout, 1'b0);

        // R6 top bits equal: generate or kill at the top
        apply(16'h8000, 16'h8000, 1'b0);
        check_bit("R6 cout", cout, 1'b1);
        apply(16'h7FFF, 16'h7FFF, 1'b1);
        check_bit("R6 cout", cout, 1'b0);
        apply(16'hFFFF, 16'h8000, 1'b0);
        check_bit("R6 cout", cout, 1'b1);

        // Single carry travelling through each bit position
        for (int i = 0; i < WIDTH; i++) begin
            apply(16'(1) << i, 16'(1) << i, 1'b0);
            apply((16'(1) << i) - 16'(1), 16'(1), 1'b0);
        end

        // Random operands, R1 and R2
        for (int n = 0; n < 400; n++) begin
            apply(WIDTH'($urandom), WIDTH'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule